// File: doc/BRIEF.md
# Cause-Dependent Reset Sequencer

This block collects six internal reset requests into a single internal reset and times how that reset is released. The requests are power-on, low-voltage detect, watchdog timeout, illegal opcode, illegal address and a manual/module reset. It runs on the crystal-derived reference clock. A power-on or low-voltage cause first holds the CPU and peripheral clocks off for an oscillator settling window. A common phase follows for every cause: the device pulls the external reset pin low for a while, then waits a little longer. A short strobe at the end tells the CPU it may fetch its reset vector.

A six-bit status register records which cause produced the latest reset. A power-on cause records only itself. Any other cause records the sources that fired and clears the rest. Pulsing the read strobe empties the register. The watchdog request arrives without any relation to the reference clock, so it passes through a synchroniser before use. Any request that arrives while a sequence is running starts the sequence again from its first phase.

Top module: `rstseq_top`

## Requirements
- R1: Any one of the six request inputs starts a sequence: `int_rst` goes high no later than the cycle after the request (the watchdog adds its synchroniser latency).
- R2: The watchdog request passes through a two-stage synchroniser. A one-cycle watchdog pulse then yields the same sequence as any other short cause.
- R3: A power-on or low-voltage request opens with a 4096-cycle settling phase. `clk_hold` is high for exactly those 4096 cycles and for no others.
- R4: Every sequence contains a 64-cycle common phase. `pin_drv_n` is low for its first 32 cycles, so it starts right after the settling phase for long causes and in the first cycle for short ones. The pin then stays released for the remaining 32 cycles.
- R5: `vec_fetch` is high for 3 cycles right after `int_rst` falls. `int_rst` plus `vec_fetch` span exactly 4163 cycles for long causes and 67 for short ones.
- R6: A power-on request makes the status equal 6'b000001 and clears every other bit. This holds even when other requests arrive in the same cycle.
- R7: Without power-on, the status becomes exactly the set of requesting sources and all other bits clear. The bit positions are: bit0 power-on, bit1 low-voltage, bit2 watchdog, bit3 illegal opcode, bit4 illegal address, bit5 manual.
- R8: Pulsing `stat_rd` with no request present clears all status bits on the next cycle. A request in the same cycle takes precedence over the read.
- R9: A request that arrives during a sequence restarts it: a long cause restarts at the settling phase and a short cause at the common phase. The full length is counted again from the restart.
- R10: After `rst`, the outputs are `int_rst`=0, `pin_drv_n`=1, `clk_hold`=0, `vec_fetch`=0 and status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer itself |
| req_pwron | input | 1 | Power-on request, one-cycle pulse |
| req_lowv | input | 1 | Low-voltage detect request |
| req_wdog | input | 1 | Watchdog timeout request, asynchronous |
| req_ill_op | input | 1 | Illegal opcode request |
| req_ill_addr | input | 1 | Illegal address request |
| req_manual | input | 1 | Manual/module reset request |
| stat_rd | input | 1 | Status read strobe; clears status |
| int_rst | output | 1 | Internal reset, active high |
| pin_drv_n | output | 1 | External pin pull-down enable, active low |
| clk_hold | output | 1 | Holds CPU and module clocks off |
| vec_fetch | output | 1 | Reset-vector fetch window |
| stat_q | output | 6 | Reset cause status |

## Verification
Each of the six causes is fired alone. This shows the two sequence lengths apart: 4163 cycles against 67, a pin window that starts after 4096 cycles against one that starts at once, and a clock hold that either appears or does not. It also checks that each cause lands in its own status bit. Simultaneous requests show the power-on exclusivity apart from the ordinary case where several bits are set together. Restarts in mid-sequence, using both a short and a long second cause, show a full recount apart from a run that just carries on. Reads with and without a competing request show clearing apart from request precedence.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Sequence phases, in release order
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_STAB = 3'd1,
        PH_DRV  = 3'd2,
        PH_HOLD = 3'd3,
        PH_VEC  = 3'd4
    } phase_e;

    // Reset causes; first member is the MSB, so pwron sits at bit 0
    typedef struct packed {
        logic manual;
        logic ill_addr;
        logic ill_op;
        logic wdog;
        logic lowv;
        logic pwron;
    } cause_t;

    localparam int NUM_CAUSES = $bits(cause_t);

    function automatic logic needs_settle(cause_t c);
        return c.pwron | c.lowv;
    endfunction

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_STAB: return PH_DRV;
            PH_DRV:  return PH_HOLD;
            PH_HOLD: return PH_VEC;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t req,
    input  logic   rd,
    output cause_t stat
);
    localparam cause_t ONLY_PWRON = cause_t'(NUM_CAUSES'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (req != '0) begin
            stat <= req.pwron ? ONLY_PWRON : req;
        end else if (rd) begin
            stat <= '0;
        end
    end

    AST_PWRON_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        req.pwron |=> (stat == ONLY_PWRON)); // R6
    AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (rst)
        ((req != '0) && !req.pwron) |=> (stat == $past(req))); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd && (req == '0)) |=> (stat == '0)); // R8
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int STAB_CYC = 4096,
    parameter int DRV_CYC  = 32,
    parameter int HOLD_CYC = 32,
    parameter int VEC_CYC  = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   start_long,
    output phase_e phase
);
    localparam int MAXC = max4(STAB_CYC, DRV_CYC, HOLD_CYC, VEC_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    function automatic logic [CW-1:0] load_of(phase_e p);
        case (p)
            PH_STAB: return CW'(STAB_CYC - 1);
            PH_DRV:  return CW'(DRV_CYC - 1);
            PH_HOLD: return CW'(HOLD_CYC - 1);
            PH_VEC:  return CW'(VEC_CYC - 1);
            default: return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= start_long ? PH_STAB : PH_DRV;
            cnt   <= start_long ? load_of(PH_STAB) : load_of(PH_DRV);
        end else if (phase != PH_IDLE) begin
            if (cnt == '0) begin
                phase <= phase_after(phase);
                cnt   <= load_of(phase_after(phase));
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase != PH_IDLE)); // R9
    AST_STAB_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_STAB) && !start) |=> ((phase == PH_STAB) || (phase == PH_DRV))); // R3
    AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_HOLD) && !start) |=> ((phase == PH_HOLD) || (phase == PH_VEC))); // R4
    AST_VEC_ENDS: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_VEC) && (cnt == '0) && !start) |=> (phase == PH_IDLE)); // R5
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int STAB_CYC    = 4096,
    parameter int DRV_CYC     = 32,
    parameter int HOLD_CYC    = 32,
    parameter int VEC_CYC     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_pwron,
    input  logic       req_lowv,
    input  logic       req_wdog,
    input  logic       req_ill_op,
    input  logic       req_ill_addr,
    input  logic       req_manual,
    input  logic       stat_rd,
    output logic       int_rst,
    output logic       pin_drv_n,
    output logic       clk_hold,
    output logic       vec_fetch,
    output logic [5:0] stat_q
);
    logic   wdog_sync;
    cause_t req;
    cause_t stat;
    phase_e phase;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_wdog_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_wdog),
        .q   (wdog_sync)
    );

    always_comb begin
        req          = '0;
        req.pwron    = req_pwron;
        req.lowv     = req_lowv;
        req.wdog     = wdog_sync;
        req.ill_op   = req_ill_op;
        req.ill_addr = req_ill_addr;
        req.manual   = req_manual;
    end

    rstseq_timer #(
        .STAB_CYC (STAB_CYC),
        .DRV_CYC  (DRV_CYC),
        .HOLD_CYC (HOLD_CYC),
        .VEC_CYC  (VEC_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (req != '0),
        .start_long (needs_settle(req)),
        .phase      (phase)
    );

    rstseq_cause u_cause (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .rd   (stat_rd),
        .stat (stat)
    );

    always_comb begin
        int_rst   = (phase == PH_STAB) || (phase == PH_DRV) || (phase == PH_HOLD);
        pin_drv_n = (phase != PH_DRV);
        clk_hold  = (phase == PH_STAB);
        vec_fetch = (phase == PH_VEC);
    end

    assign stat_q = stat;

    AST_PIN_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !pin_drv_n |-> (int_rst && !clk_hold)); // R4
    AST_VEC_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        vec_fetch |-> !int_rst); // R5
    AST_HOLD_NO_PIN: assert property (@(posedge clk) disable iff (rst)
        clk_hold |-> (int_rst && pin_drv_n)); // R3
    AST_REQ_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        (req_pwron || req_manual || req_ill_op) |=> int_rst); // R1
endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_pwron = 0, req_lowv = 0, req_wdog = 0;
    logic req_ill_op = 0, req_ill_addr = 0, req_manual = 0;
    logic stat_rd = 0;
    logic int_rst, pin_drv_n, clk_hold, vec_fetch;
    logic [5:0] stat_q;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int m_total, m_rst, m_pin, m_hold, m_vec, m_pin_at;

    always #5 clk = ~clk;

    rstseq_top uut (
        .clk(clk), .rst(rst),
        .req_pwron(req_pwron), .req_lowv(req_lowv), .req_wdog(req_wdog),
        .req_ill_op(req_ill_op), .req_ill_addr(req_ill_addr), .req_manual(req_manual),
        .stat_rd(stat_rd),
        .int_rst(int_rst), .pin_drv_n(pin_drv_n), .clk_hold(clk_hold),
        .vec_fetch(vec_fetch), .stat_q(stat_q)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // bits: 0 pwron,1 lowv,2 wdog,3 ill_op,4 ill_addr,5 manual
    task automatic drive(input logic [5:0] c);
        req_pwron    = c[0];
        req_lowv     = c[1];
        req_wdog     = c[2];
        req_ill_op   = c[3];
        req_ill_addr = c[4];
        req_manual   = c[5];
    endtask

    task automatic pulse(input logic [5:0] c);
        @(negedge clk);
        drive(c);
        @(negedge clk);
        drive(6'b0);
    endtask

    task automatic measure();
        int guard = 0;
        m_total = 0; m_rst = 0; m_pin = 0; m_hold = 0; m_vec = 0; m_pin_at = -1;
        while (!int_rst && guard < 8) begin
            @(negedge clk);
            guard++;
        end
        while ((int_rst || vec_fetch) && m_total < 10000) begin
            if (int_rst) m_rst++;
            if (!pin_drv_n) begin
                m_pin++;
                if (m_pin_at < 0) m_pin_at = m_total;
            end
            if (clk_hold) m_hold++;
            if (vec_fetch) m_vec++;
            m_total++;
            @(negedge clk);
        end
    endtask

    task automatic run_cause(input string name, input logic [5:0] c, input bit long_c);
        pulse(c);
        measure();
        check({name, " R1/R5 total"}, m_total, long_c ? 4163 : 67);
        check({name, " R5 vec"}, m_vec, 3);
        check({name, " R5 int_rst"}, m_rst, long_c ? 4160 : 64);
        check({name, " R3 clk_hold"}, m_hold, long_c ? 4096 : 0);
        check({name, " R4 pin len"}, m_pin, 32);
        check({name, " R4 pin start"}, m_pin_at, long_c ? 4096 : 0);
        check({name, " R6/R7 status"}, stat_q, c[0] ? 1 : c);
    endtask

    task automatic test_reset_state();
        check("R10 int_rst", int_rst, 0);
        check("R10 pin_drv_n", pin_drv_n, 1);
        check("R10 clk_hold", clk_hold, 0);
        check("R10 vec_fetch", vec_fetch, 0);
        check("R10 status", stat_q, 0);
    endtask

    task automatic test_single_causes();
        run_cause("pwron", 6'b000001, 1);
        run_cause("lowv", 6'b000010, 1);
        run_cause("R2 wdog", 6'b000100, 0);
        run_cause("ill_op", 6'b001000, 0);
        run_cause("ill_addr", 6'b010000, 0);
        run_cause("manual", 6'b100000, 0);
    endtask

    task automatic test_read_clear();
        @(negedge clk);
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        check("R8 read clears", stat_q, 0);
        // read competing with a request: request wins
        @(negedge clk);
        stat_rd = 1;
        drive(6'b001000);
        @(negedge clk);
        stat_rd = 0;
        drive(6'b0);
        check("R8 request beats read", stat_q, 6'b001000);
        measure();
        check("R8 seq after read", m_total, 67);
    endtask

    task automatic test_simultaneous();
        run_cause("R6 pwron+ill_op", 6'b001001, 1);
        run_cause("R7 ill_op+manual", 6'b101000, 0);
    endtask

    task automatic test_restart();
        pulse(6'b001000);
        repeat (40) @(negedge clk);
        check("R9 mid-seq busy", int_rst, 1);
        pulse(6'b010000);
        measure();
        check("R9 short restart total", m_total, 67);
        check("R9 short restart pin", m_pin, 32);
        check("R9 short restart status", stat_q, 6'b010000);
        pulse(6'b100000);
        repeat (10) @(negedge clk);
        pulse(6'b000010);
        measure();
        check("R9 long restart total", m_total, 4163);
        check("R9 long restart hold", m_hold, 4096);
        check("R9 long restart pin start", m_pin_at, 4096);
        check("R9 long restart status", stat_q, 6'b000010);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset_state();
        test_single_causes();
        test_read_clear();
        test_simultaneous();
        test_restart();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule